// File: doc/BRIEF.md
# Four-Channel Aligned Pulse-Width Generator

This block contains four pulse-width channels that run independently of each other. Each channel has a counter that steps on one line of an externally supplied tick vector. A four-bit source code in the channel's mode register picks that line. The counter either runs as a sawtooth (left-aligned) or as a triangle (centre-aligned). A duty compare against the count sets the output level, and a polarity bit chooses whether the period opens at the high or the low level.

Every channel drives two lines. The second line either copies the first or is its complement. Configuration arrives through a single-cycle write port: one address field selects the register kind, the other selects the channel. Channels are started and stopped with set and clear masks. A channel's mode can only be changed while that channel is stopped. A mode write aimed at a running channel is dropped and raises a sticky error flag.

Top module: `pwm4_gen`

## Requirements
- R1: Four channels, indexed 0 to 3, are configured and run independently. A write with `wr_en_i` high uses address bits [3:2] as the register kind (0 control, 1 mode, 2 period, 3 duty) and bits [1:0] as the channel index.
- R2: A control write to channel index 0 sets `en_o` bits where the data holds a 1. A control write to index 1 clears `en_o` bits where the data holds a 1. Zero bits in either mask leave the matching channel unchanged.
- R3: With mode bit 8 at 0 (left-aligned), the counter steps 0 to period−1 and wraps. The output sits at the active level while the count is below the duty value, so each period of P ticks holds D active ticks.
- R4: With mode bit 8 at 1 (centre-aligned), the counter climbs to the period and descends to 0, giving a 2P-tick cycle. For 0 < D < P, that cycle holds 2D−1 active ticks in one symmetric pulse.
- R5: Mode bit 9 is the start (active) level: 1 makes the output high while the count is below the duty value, and 0 makes it low.
- R6: Mode bit 10 at 0 makes `pwm_b_o` equal `pwm_a_o` on an enabled channel. At 1 it makes `pwm_b_o` the complement of `pwm_a_o`.
- R7: Mode bits [3:0] select which bit of `tick_i` advances the counter. The counter holds in any cycle where that bit is low.
- R8: A disabled channel drives both lines to the inverse of its mode bit 9, and holds its counter at 0 from the following cycle on.
- R9: A mode write to an enabled channel leaves its configuration unchanged and sets `mode_err_o`, which stays set until reset. Mode writes to a disabled channel are accepted.
- R10: A duty of 0 holds the output at the inactive level. A duty equal to or above the period holds it at the active level. Neither case produces a pulse.
- R11: After reset, all channels are disabled, all mode, period and duty values are 0, `mode_err_o` is 0, and every output line is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register kind [3:2] and channel index [1:0] |
| wr_data_i | input | 16 | Write data |
| tick_i | input | 16 | Tick lines, one selected per channel by its source code |
| pwm_a_o | output | 4 | First output line of each channel |
| pwm_b_o | output | 4 | Second output line of each channel |
| en_o | output | 4 | Channel enable state |
| mode_err_o | output | 1 | Sticky flag for a rejected mode write |

## Verification
The channels are measured over windows that are exactly one waveform cycle long, so the number of active samples has to match the duty value whatever the phase. A left-aligned channel must give D per P cycles and a centre-aligned one must give 2D−1 per 2P cycles, which tells the sawtooth apart from the triangle. A channel fed from a half-rate tick line must take twice the cycles for the same count, which separates correct source selection from free running. Duties of 0, exactly the period, and above the period, combined with both polarities and both pair settings, separate a correct compare from off-by-one glitches and from line swaps. A mode write to a running channel is followed by a measurement that must still show the old waveform.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
  localparam int unsigned SRC_W = 4;
  localparam int unsigned TICK_W = 1 << SRC_W;

  // mode word bit positions
  localparam int unsigned MB_ALIGN = 8;
  localparam int unsigned MB_START = 9;
  localparam int unsigned MB_PAIR  = 10;

  typedef struct packed {
    logic             pair_inv;
    logic             start_hi;
    logic             centre;
    logic [SRC_W-1:0] src;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_PER  = 2'd2,
    SEL_DUTY = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int CH_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [CH_W+1:0]               wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [NUM_CH-1:0]             en_q,
  output chan_cfg_t [NUM_CH-1:0]        cfg_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]  per_q,
  output logic [NUM_CH-1:0][CNT_W-1:0]  duty_q,
  output logic                          err_q
);
  logic [NUM_CH-1:0]            en_d;
  chan_cfg_t [NUM_CH-1:0]       cfg_d;
  logic [NUM_CH-1:0][CNT_W-1:0] per_d;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_d;
  logic                         err_d;
  reg_sel_e                     sel;
  logic [CH_W-1:0]              ch_idx;

  assign sel    = reg_sel_e'(wr_addr_i[CH_W+1:CH_W]);
  assign ch_idx = wr_addr_i[CH_W-1:0];

  always_comb begin
    en_d   = en_q;
    cfg_d  = cfg_q;
    per_d  = per_q;
    duty_d = duty_q;
    err_d  = err_q;
    if (wr_en_i) begin
      unique case (sel)
        SEL_CTL: begin
          if (ch_idx == CH_W'(0))      en_d = en_q | wr_data_i[NUM_CH-1:0];
          else if (ch_idx == CH_W'(1)) en_d = en_q & ~wr_data_i[NUM_CH-1:0];
        end
        SEL_MODE: begin
          if (en_q[ch_idx]) begin
            err_d = 1'b1;
          end else begin
            cfg_d[ch_idx].src      = wr_data_i[SRC_W-1:0];
            cfg_d[ch_idx].centre   = wr_data_i[MB_ALIGN];
            cfg_d[ch_idx].start_hi = wr_data_i[MB_START];
            cfg_d[ch_idx].pair_inv = wr_data_i[MB_PAIR];
          end
        end
        SEL_PER:  per_d[ch_idx]  = wr_data_i[CNT_W-1:0];
        SEL_DUTY: duty_d[ch_idx] = wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      cfg_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      cfg_q  <= cfg_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm4_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              en_i,
  input  chan_cfg_t         cfg_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  duty_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic              line_a_o,
  output logic              line_b_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             step;
  logic             active;
  logic             level;

  assign step = tick_i[cfg_i.src];

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (!en_i || period_i == '0) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else if (step) begin
      if (!cfg_i.centre) begin
        down_d = 1'b0;
        cnt_d  = (cnt_q >= period_i - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
      end else if (!down_q) begin
        if (cnt_q >= period_i) begin
          down_d = 1'b1;
          cnt_d  = cnt_q - CNT_W'(1);
        end else begin
          cnt_d  = cnt_q + CNT_W'(1);
        end
      end else if (cnt_q == '0) begin
        down_d = 1'b0;
        cnt_d  = CNT_W'(1);
      end else begin
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  // duty 0 never active; duty at or above the period always active
  assign active   = (duty_i != '0) && ((duty_i >= period_i) || (cnt_q < duty_i));
  assign level    = cfg_i.start_hi ? active : ~active;
  assign line_a_o = en_i ? level : ~cfg_i.start_hi;
  assign line_b_o = en_i ? (level ^ cfg_i.pair_inv) : ~cfg_i.start_hi;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/pwm4_gen.sv
module pwm4_gen
  import pwm4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [NUM_CH-1:0] pwm_a_o,
  output logic [NUM_CH-1:0] pwm_b_o,
  output logic [NUM_CH-1:0] en_o,
  output logic              mode_err_o
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_n_int;
  logic [NUM_CH-1:0]            en_q;
  chan_cfg_t [NUM_CH-1:0]       cfg_q;
  logic [NUM_CH-1:0][CNT_W-1:0] per_q;
  logic [NUM_CH-1:0][CNT_W-1:0] duty_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .CH_W   (CH_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_n     (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_q      (en_q),
    .cfg_q     (cfg_q),
    .per_q     (per_q),
    .duty_q    (duty_q),
    .err_q     (mode_err_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_n    (rst_n_int),
      .en_i     (en_q[i]),
      .cfg_i    (cfg_q[i]),
      .period_i (per_q[i]),
      .duty_i   (duty_q[i]),
      .tick_i   (tick_i),
      .line_a_o (pwm_a_o[i]),
      .line_b_o (pwm_b_o[i]),
      .cnt_o    (cnt_all[i])
    );
  end

  assign en_o = en_q;
endmodule

// File: rtl/pwm4_gen_sva.sv
module pwm4_gen_sva
  import pwm4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int CH_W   = 2
) (
  input logic                         clk_i,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic [CH_W+1:0]              wr_addr,
  input logic [TICK_W-1:0]            tick,
  input logic [NUM_CH-1:0]            en,
  input chan_cfg_t [NUM_CH-1:0]       cfg,
  input logic [NUM_CH-1:0][CNT_W-1:0] period,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]            a,
  input logic [NUM_CH-1:0]            b,
  input logic                         err
);
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    err |=> err);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_mode_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
      (wr_en && wr_addr[CH_W+1:CH_W] == 2'd1 && wr_addr[CH_W-1:0] == CH_W'(i) && en[i])
      |=> ($stable(cfg[i]) && err));

    p_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
      en[i] |-> (b[i] == (a[i] ^ cfg[i].pair_inv)));

    p_idle_level_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      !en[i] |-> (a[i] == ~cfg[i].start_hi && b[i] == ~cfg[i].start_hi));

    p_idle_count_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
      !en[i] |=> (cnt[i] == '0));

    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en[i] && period[i] != '0 && !tick[cfg[i].src]) |=> $stable(cnt[i]));

    p_left_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en[i] && !cfg[i].centre && period[i] != '0 && tick[cfg[i].src]
       && cnt[i] >= period[i] - CNT_W'(1)) |=> (cnt[i] == '0));

    p_const_off_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en[i] && duty[i] == '0) |-> (a[i] == ~cfg[i].start_hi));

    p_const_on_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      (en[i] && duty[i] != '0 && duty[i] >= period[i]) |-> (a[i] == cfg[i].start_hi));
  end
endmodule

bind pwm4_gen pwm4_gen_sva #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .CH_W   (CH_W)
) u_sva (
  .clk_i   (clk_i),
  .rst_n   (rst_n_int),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .tick    (tick_i),
  .en      (en_q),
  .cfg     (cfg_q),
  .period  (per_q),
  .duty    (duty_q),
  .cnt     (cnt_all),
  .a       (pwm_a_o),
  .b       (pwm_b_o),
  .err     (mode_err_o)
);

// File: tb/pwm4_gen_bench.sv
module pwm4_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] tick;
  logic [3:0]  pa, pb, en;
  logic        err;

  int checks = 0;
  int fails  = 0;
  int issued = 0;
  int done   = 0;
  bit finished = 0;

  typedef struct {
    int    ch;
    int    win;
    int    exp_hi;
    bit    inv;
    string tag;
  } item_t;
  item_t sb_q[$];

  pwm4_gen u_pwm4_gen (
    .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .pwm_a_o(pa), .pwm_b_o(pb),
    .en_o(en), .mode_err_o(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // tick line 0 every cycle, line 1 every other cycle
  initial begin
    tick = 16'h0001;
    forever begin
      @(negedge clk);
      tick[1] = ~tick[1];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {kind, ch}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push an expected window, wait for the monitor to judge it
  task automatic expect_win(input int ch, input int win, input int exp_hi,
                            input bit inv, input string tag);
    item_t it;
    it.ch = ch; it.win = win; it.exp_hi = exp_hi; it.inv = inv; it.tag = tag;
    sb_q.push_back(it);
    issued++;
    wait (done == issued);
  endtask

  // monitor: count active samples over the window and check the pair relation
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        int hi;
        int pair_bad;
        it = sb_q.pop_front();
        hi = 0; pair_bad = 0;
        for (int k = 0; k < it.win; k++) begin
          if (k > 0) @(negedge clk);
          if (pa[it.ch]) hi++;
          if (pb[it.ch] != (pa[it.ch] ^ it.inv)) pair_bad++;
        end
        chk(hi == it.exp_hi, it.tag, hi, it.exp_hi);
        chk(pair_bad == 0, {it.tag, " pair R6"}, pair_bad, 0);
        done++;
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R11 reset state
    chk(en == 4'h0, "R11 en", en, 0);
    chk(err == 1'b0, "R11 err", err, 0);
    chk(pa == 4'hF && pb == 4'hF, "R11 lines", {pa, pb}, 8'hFF);

    // R3: ch0 left, start high, same pair, P=10 D=3
    wr(2'd1, 2'd0, 16'h0200);
    wr(2'd2, 2'd0, 16'd10);
    wr(2'd3, 2'd0, 16'd3);
    wr(2'd0, 2'd0, 16'h0001);
    chk(en == 4'h1, "R2 set", en, 1);
    idle(3);
    expect_win(0, 10, 3, 1'b0, "R3 left P10 D3");
    expect_win(0, 20, 6, 1'b0, "R3 left two periods");

    // R4/R6: ch1 centre, start high, inverted pair, P=8 D=3
    wr(2'd1, 2'd1, 16'h0700);
    wr(2'd2, 2'd1, 16'd8);
    wr(2'd3, 2'd1, 16'd3);
    wr(2'd0, 2'd0, 16'h0002);
    chk(en == 4'h3, "R2 zero bits keep", en, 3);
    idle(3);
    expect_win(1, 16, 5, 1'b1, "R4 centre P8 D3");

    // R5: ch2 left, start low, P=10 D=4 -> high 6
    wr(2'd1, 2'd2, 16'h0000);
    wr(2'd2, 2'd2, 16'd10);
    wr(2'd3, 2'd2, 16'd4);
    wr(2'd0, 2'd0, 16'h0004);
    idle(3);
    expect_win(2, 10, 6, 1'b0, "R5 start low");

    // R7: ch3 on half-rate tick, P=6 D=2 -> 12 cycles, 4 high
    wr(2'd1, 2'd3, 16'h0201);
    wr(2'd2, 2'd3, 16'd6);
    wr(2'd3, 2'd3, 16'd2);
    wr(2'd0, 2'd0, 16'h0008);
    chk(en == 4'hF, "R1 all enabled", en, 15);
    idle(4);
    expect_win(3, 12, 4, 1'b0, "R7 half-rate tick");
    expect_win(0, 10, 3, 1'b0, "R1 ch0 undisturbed");

    // R9: mode write to running ch0 rejected
    wr(2'd1, 2'd0, 16'h0000);
    chk(err == 1'b1, "R9 err set", err, 1);
    idle(2);
    expect_win(0, 10, 3, 1'b0, "R9 mode kept");

    // R10: duty corners
    wr(2'd3, 2'd0, 16'd0);
    idle(2);
    expect_win(0, 10, 0, 1'b0, "R10 duty zero");
    wr(2'd3, 2'd0, 16'd10);
    idle(2);
    expect_win(0, 10, 10, 1'b0, "R10 duty eq period");
    wr(2'd3, 2'd0, 16'd50);
    idle(2);
    expect_win(0, 10, 10, 1'b0, "R10 duty above period");
    wr(2'd3, 2'd1, 16'd8);
    idle(2);
    expect_win(1, 16, 16, 1'b1, "R10 centre duty eq period");

    // R8: disable ch0 (start high) -> both lines low
    wr(2'd0, 2'd1, 16'h0001);
    chk(en == 4'hE, "R2 clear", en, 14);
    expect_win(0, 5, 0, 1'b0, "R8 idle level");
    wr(2'd0, 2'd1, 16'h0000);
    chk(en == 4'hE, "R2 zero clear mask", en, 14);

    // R9: mode write accepted while disabled; err stays
    wr(2'd1, 2'd0, 16'h0000);
    chk(err == 1'b1, "R9 err sticky", err, 1);
    expect_win(0, 3, 3, 1'b0, "R9 accepted idle level");
    wr(2'd0, 2'd0, 16'h0001);
    idle(2);
    expect_win(0, 10, 0, 1'b0, "R5 active low full duty");

    // R8: stop everything, ch2 (start low) idles high
    wr(2'd0, 2'd1, 16'h000F);
    chk(en == 4'h0, "R2 clear all", en, 0);
    expect_win(2, 4, 4, 1'b0, "R8 idle start-low");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule